// File: doc/BRIEF.md
# Watermark-Bounded Slave-FIFO Read Controller

This block drains host-to-device data from a synchronous slave-FIFO port of a USB bridge into a local valid/ready stream. The bridge fills two 16 KB buffers alternately. For each one it raises a buffer-ready flag, and it raises a partial flag as the buffer nears empty. The controller drives the select, read and output-enable strobes (all active low). It reads a buffer only while that buffer is committed. Once the partial flag is seen, it issues exactly the number of further reads the watermark allows and then stops until the next buffer is announced. The data bus is 32 bits wide, so each read moves one 4-byte word, and the watermark-to-word ratio is one.

A transfer whose length is not a multiple of the buffer size ends in a short buffer. The short buffer can hold fewer words than a large watermark would allow. There are two ways to handle this. The first is to set the watermark as low as 1. The second is for the sender to pad the tail so the last buffer holds watermark-minus-one words, and the controller then drops the configured number of trailing pad words instead of forwarding them. Watermark, total word count (pad included) and pad count are latched when a transfer starts. Read data is captured two clocks after its strobe. A four-entry holding buffer absorbs words already in flight when the consumer stalls.

The control sequence is:
- ST_IDLE goes to ST_WAIT_READY on start.
- ST_WAIT_READY goes to ST_BURST when the ready flag is seen.
- ST_BURST goes to ST_DRAIN when the partial flag is seen.
- ST_DRAIN goes to ST_BUF_DONE when the post-watermark budget is spent.
- ST_BUF_DONE goes to ST_WAIT_READY if words remain, or to ST_IDLE with a done pulse once everything is delivered.

Top module: `fifo_drain_ctrl`

## Requirements
- R1: Out of reset, rd_n, cs_n and oe_n are high, out_valid is low and done is low.
- R2: No read strobe (rd_n low) is issued while the bridge holds no committed word, including between buffers before the ready flag reasserts.
- R3: After the clock edge where flag_partial is sampled high during a burst, exactly watermark − 1 further read strobes are issued, and then reading stops until flag_ready is seen again.
- R4: A watermark of 1 issues no further reads after the partial flag, so a final buffer holding a single word is read without over-read.
- R5: Each read strobe yields exactly one word, taken from bus_data two clocks after the strobe, and words are forwarded in the order read.
- R6: While out_ready is low, out_valid and out_data hold, no word is lost, and reads pause once the holding buffer and in-flight reads fill it.
- R7: The holding buffer never holds more than its depth (4 words).
- R8: The last cfg_pad_words words read in a transfer are discarded, so exactly cfg_total_words − cfg_pad_words words reach the output.
- R9: done pulses high for exactly one cycle per transfer, after the last kept word has been accepted downstream.
- R10: cfg_watermark, cfg_total_words and cfg_pad_words are sampled only with start in ST_IDLE. Changing them during a transfer has no effect on it.
- R11: cs_n is low for the whole transfer, and rd_n low always coincides with cs_n low and oe_n low. cs_n and oe_n are high again once the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled in ST_IDLE) |
| cfg_watermark | input | WM_W | Words of watermark, 1 or more |
| cfg_total_words | input | CNT_W | Words to read, pad included |
| cfg_pad_words | input | CNT_W | Trailing words to discard, less than the total |
| flag_ready | input | 1 | Bridge buffer committed and readable |
| flag_partial | input | 1 | Bridge watermark flag for the same thread |
| bus_data | input | DATA_W | Slave-FIFO read data |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| out_data | output | DATA_W | Forwarded word |
| out_valid | output | 1 | out_data holds a word |
| out_ready | input | 1 | Consumer accepts the word |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
A wrong drain budget shows at the bridge port itself. Over-reading strobes rd_n on an empty buffer in the very cycle it happens. Under-reading leaves a committed word behind, so the transfer never completes and the done wait expires. A fault in the capture pipeline or the pad counter shows on the next accepted output word as wrong data, a duplicate, or an extra word beyond the kept count. Holding-buffer pointer faults show within one stall as changed data or a lost word. The bench models the bridge buffers and the expected stream behaviourally and compares the output on every clock.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_READY,
        ST_BURST,
        ST_DRAIN,
        ST_BUF_DONE
    } drain_state_e;
endpackage

// File: rtl/fdc_skid.sv
module fdc_skid #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CW-1:0]    level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            level <= level + CW'(push) - CW'(pop);
        end
    end

    assign pop_data = mem[rd_ptr];
endmodule

// File: rtl/fdc_capture.sv
module fdc_capture #(
    parameter int WIDTH = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rd_strobe,
    input  logic [WIDTH-1:0] bus_data,
    input  logic [CNT_W-1:0] keep_words,
    output logic             pipe_busy,
    output logic             push,
    output logic [WIDTH-1:0] push_data
);
    logic             stage_q;
    logic [CNT_W-1:0] seen_q;

    // The strobe register is one stage; this is the second, so data is
    // taken two edges after the strobe was decided.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= 1'b0;
            seen_q  <= '0;
        end else begin
            stage_q <= rd_strobe;
            if (clear) begin
                seen_q <= '0;
            end else if (stage_q) begin
                seen_q <= seen_q + 1'b1;
            end
        end
    end

    assign pipe_busy = stage_q;
    assign push      = stage_q && (seen_q < keep_words);
    assign push_data = bus_data;
endmodule

// File: rtl/fifo_drain_ctrl.sv
module fifo_drain_ctrl
    import fdc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 16,
    parameter int WM_W       = 4,
    parameter int SKID_DEPTH = 4,
    localparam int LVL_W     = $clog2(SKID_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WM_W-1:0]   cfg_watermark,
    input  logic [CNT_W-1:0]  cfg_total_words,
    input  logic [CNT_W-1:0]  cfg_pad_words,
    input  logic              flag_ready,
    input  logic              flag_partial,
    input  logic [DATA_W-1:0] bus_data,
    output logic              cs_n,
    output logic              rd_n,
    output logic              oe_n,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              done
);
    drain_state_e      state_q, state_d;
    logic [WM_W-1:0]   wm_q;
    logic [CNT_W-1:0]  total_q, keep_q, issued_q;
    logic [WM_W-1:0]   drain_q, drain_d;
    logic              rd_q, issue, finish;
    logic              pipe_busy, push, pop;
    logic [DATA_W-1:0] push_data;
    logic [LVL_W-1:0]  level;
    logic [LVL_W+1:0]  in_use;
    logic              space_ok, all_issued, can_go, load_cfg;

    assign load_cfg   = (state_q == ST_IDLE) && start;
    assign in_use     = (LVL_W + 2)'(level) + (LVL_W + 2)'(rd_q) + (LVL_W + 2)'(pipe_busy);
    assign space_ok   = in_use < (LVL_W + 2)'(SKID_DEPTH);
    assign all_issued = (issued_q == total_q);
    assign can_go     = out_ready && space_ok && !all_issued;
    assign out_valid  = (level != '0);
    assign pop        = out_valid && out_ready;

    // Next state and read decision
    always_comb begin
        state_d = state_q;
        drain_d = drain_q;
        issue   = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_WAIT_READY;
            end
            ST_WAIT_READY: begin
                if (flag_ready) state_d = ST_BURST;
            end
            ST_BURST: begin
                if (flag_partial) begin
                    state_d = ST_DRAIN;
                    drain_d = (wm_q == '0) ? '0 : wm_q - 1'b1;
                end else begin
                    issue = can_go;
                end
            end
            ST_DRAIN: begin
                if (drain_q == '0) begin
                    state_d = ST_BUF_DONE;
                end else begin
                    issue = can_go;
                    if (can_go) drain_d = drain_q - 1'b1;
                end
            end
            ST_BUF_DONE: begin
                if (!rd_q && !pipe_busy) begin
                    if (!all_issued) begin
                        state_d = ST_WAIT_READY;
                    end else if (level == '0) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and transfer bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            drain_q  <= '0;
            wm_q     <= '0;
            total_q  <= '0;
            keep_q   <= '0;
            issued_q <= '0;
        end else begin
            state_q <= state_d;
            drain_q <= drain_d;
            if (load_cfg) begin
                wm_q     <= cfg_watermark;
                total_q  <= cfg_total_words;
                keep_q   <= cfg_total_words - cfg_pad_words;
                issued_q <= '0;
            end else if (issue) begin
                issued_q <= issued_q + 1'b1;
            end
        end
    end

    // Registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            cs_n <= 1'b1;
            oe_n <= 1'b1;
            done <= 1'b0;
        end else begin
            rd_q <= issue;
            cs_n <= (state_d == ST_IDLE);
            oe_n <= !((state_d == ST_BURST) || (state_d == ST_DRAIN) ||
                      (state_d == ST_BUF_DONE));
            done <= finish;
        end
    end

    assign rd_n = !rd_q;

    fdc_capture #(.WIDTH(DATA_W), .CNT_W(CNT_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (load_cfg),
        .rd_strobe (rd_q),
        .bus_data  (bus_data),
        .keep_words(keep_q),
        .pipe_busy (pipe_busy),
        .push      (push),
        .push_data (push_data)
    );

    fdc_skid #(.WIDTH(DATA_W), .DEPTH(SKID_DEPTH)) u_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_data(push_data),
        .pop      (pop),
        .pop_data (out_data),
        .level    (level)
    );
endmodule

// File: rtl/fdc_checker.sv
module fdc_checker
    import fdc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int WM_W       = 4,
    parameter int LVL_W      = 3,
    parameter int SKID_DEPTH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_n,
    input logic              cs_n,
    input logic              oe_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              done,
    input logic              flag_partial,
    input logic [LVL_W-1:0]  level,
    input drain_state_e      state_q,
    input logic [WM_W-1:0]   wm_q
);
    logic            armed;
    logic [WM_W:0]   post_cnt;

    // Counts strobes seen after the partial flag was taken in a burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            post_cnt <= '0;
        end else if (state_q == ST_BURST && flag_partial) begin
            armed    <= 1'b1;
            post_cnt <= '0;
        end else if (state_q == ST_WAIT_READY || state_q == ST_IDLE) begin
            armed    <= 1'b0;
        end else if (armed && !rd_n) begin
            post_cnt <= post_cnt + 1'b1;
        end
    end

    assert_drain_budget_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (post_cnt == '0 || post_cnt < {1'b0, wm_q}));

    assert_read_while_bursting_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> ($past(state_q) == ST_BURST || $past(state_q) == ST_DRAIN));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(SKID_DEPTH));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_strobe_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!cs_n && !oe_n));
endmodule

bind fifo_drain_ctrl fdc_checker #(
    .DATA_W(DATA_W), .WM_W(WM_W), .LVL_W(LVL_W), .SKID_DEPTH(SKID_DEPTH)
) u_fdc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_n        (rd_n),
    .cs_n        (cs_n),
    .oe_n        (oe_n),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .done        (done),
    .flag_partial(flag_partial),
    .level       (level),
    .state_q     (state_q),
    .wm_q        (wm_q)
);

// File: tb/test_fifo_drain_ctrl.sv
module test_fifo_drain_ctrl;
    localparam int DATA_W = 32, CNT_W = 16, WM_W = 4;
    localparam int BUF_WORDS = 8, GAP = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n, start, out_ready;
    logic [WM_W-1:0]   cfg_watermark;
    logic [CNT_W-1:0]  cfg_total_words, cfg_pad_words;
    logic              flag_ready, flag_partial;
    logic [DATA_W-1:0] bus_data;
    logic              cs_n, rd_n, oe_n, out_valid, done;
    logic [DATA_W-1:0] out_data;

    fifo_drain_ctrl i_fifo_drain_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_watermark(cfg_watermark), .cfg_total_words(cfg_total_words),
        .cfg_pad_words(cfg_pad_words), .flag_ready(flag_ready),
        .flag_partial(flag_partial), .bus_data(bus_data),
        .cs_n(cs_n), .rd_n(rd_n), .oe_n(oe_n), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .done(done)
    );

    // Written only by the stimulus process
    logic [DATA_W-1:0] src_words[$];
    int xfer_id = 0, exp_keep = 0, req_wm = 1, bp_mode = 0;
    int cmp_main = 0, bad_main = 0;

    // Bridge model: committed buffers of BUF_WORDS words
    int rem = 0, br_wm = 1;
    int br_xfer = 0, br_idx = 0, br_loaded = 0, br_total = 0, gapc = 0;
    int cmp_br = 0, bad_br = 0;

    assign flag_ready   = (rem > 0);
    assign flag_partial = (rem > 0) && ((rem - (rd_n ? 0 : 1)) <= (br_wm - 1));

    always @(posedge clk) begin
        int nrem;
        int chunk;
        if (!rst_n) begin
            rem      <= 0;
            bus_data <= '0;
            gapc      = 0;
        end else begin
            if (br_xfer != xfer_id) begin
                br_xfer   = xfer_id;
                br_idx    = 0;
                br_loaded = 0;
                br_total  = src_words.size();
                gapc      = 0;
                br_wm    <= req_wm;
            end
            nrem = rem;
            if (!rd_n) begin
                cmp_br++;
                if (rem == 0) begin
                    bad_br++;
                    $display("FAIL R2 read strobe with empty bridge buffer: actual words=%0d expected >0", rem);
                end else begin
                    bus_data <= src_words[br_idx];
                    br_idx++;
                    nrem = rem - 1;
                end
            end
            if (nrem == 0 && br_loaded < br_total) begin
                if (gapc >= GAP) begin
                    chunk = br_total - br_loaded;
                    if (chunk > BUF_WORDS) chunk = BUF_WORDS;
                    nrem = chunk;
                    br_loaded += chunk;
                    gapc = 0;
                end else begin
                    gapc++;
                end
            end
            rem <= nrem;
        end
    end

    // Consumer back-pressure
    logic [7:0] lfsr = 8'h5B;
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= (bp_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[2]);
    end

    // Output monitor, compared every clock
    int mon_xfer = 0, mon_idx = 0, done_seen = 0;
    int cmp_mon = 0, bad_mon = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_xfer != xfer_id) begin
                mon_xfer = xfer_id;
                mon_idx  = 0;
            end
            if (!rd_n) begin
                cmp_mon++;
                if (cs_n || oe_n) begin
                    bad_mon++;
                    $display("FAIL R11 strobe outside select: actual cs_n=%0b oe_n=%0b expected 0/0", cs_n, oe_n);
                end
            end
            if (out_valid && out_ready) begin
                cmp_mon++;
                if (mon_idx >= exp_keep) begin
                    bad_mon++;
                    $display("FAIL R8 extra word forwarded: actual index=%0d expected <%0d", mon_idx, exp_keep);
                end else if (out_data !== src_words[mon_idx]) begin
                    bad_mon++;
                    $display("FAIL R5 word %0d: actual %h expected %h", mon_idx, out_data, src_words[mon_idx]);
                end
                mon_idx++;
            end
            if (done) begin
                cmp_mon++;
                done_seen++;
                if (mon_idx != exp_keep) begin
                    bad_mon++;
                    $display("FAIL R9 done early: actual words=%0d expected %0d", mon_idx, exp_keep);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        cmp_main++;
        if (!ok) begin
            bad_main++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic run_xfer(input int tag, input int total, input int wm,
                            input int pad, input int bp, input bit twiddle);
        int d0;
        int waited;
        @(posedge clk); #1;
        src_words.delete();
        for (int i = 0; i < total; i++) src_words.push_back(32'hA500_0000 + tag * 256 + i);
        exp_keep = total - pad;
        req_wm   = wm;
        bp_mode  = bp;
        xfer_id++;
        cfg_watermark   = WM_W'(wm);
        cfg_total_words = CNT_W'(total);
        cfg_pad_words   = CNT_W'(pad);
        d0 = done_seen;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (twiddle) begin
            // R10: live configuration changes after start
            cfg_watermark   = 4'd1;
            cfg_total_words = 16'd3;
            cfg_pad_words   = 16'd0;
        end
        waited = 0;
        while (done_seen == d0 && waited < 3000) begin
            @(posedge clk); waited++;
        end
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(done_seen == d0 + 1, $sformatf("R9 done pulses in transfer %0d", tag), done_seen - d0, 1);
        chk(br_idx == total, $sformatf("R3 words drained from bridge, transfer %0d", tag), br_idx, total);
        chk(mon_idx == exp_keep, $sformatf("R8 words forwarded, transfer %0d", tag), mon_idx, exp_keep);
        chk(cs_n && oe_n && rd_n, $sformatf("R11 strobes released after transfer %0d", tag),
            {cs_n, oe_n, rd_n}, 7);
        chk(!out_valid, $sformatf("R6 nothing left buffered after transfer %0d", tag), out_valid, 0);
    endtask

    // Watchdog
    int cycles = 0;
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                $display("FAIL watchdog expired: actual cycles=%0d expected <=150000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                         cmp_main + cmp_mon + cmp_br + 1, bad_main + bad_mon + bad_br + 1);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        cfg_watermark   = '0;
        cfg_total_words = '0;
        cfg_pad_words   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_n && cs_n && oe_n, "R1 strobes high in reset", {rd_n, cs_n, oe_n}, 7);
        chk(!out_valid && !done, "R1 out_valid and done low in reset", {out_valid, done}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(rd_n && cs_n && !out_valid, "R1 idle after reset release", {rd_n, cs_n, out_valid}, 6);

        run_xfer(1, 16, 6, 0, 0, 1'b0);   // R3 full buffers, watermark 6
        run_xfer(2, 17, 1, 0, 0, 1'b0);   // R4 one-word final buffer
        run_xfer(3, 21, 6, 4, 0, 1'b1);   // R8 padded tail, R10 config change
        run_xfer(4, 24, 3, 0, 1, 1'b0);   // R6 back-pressure
        run_xfer(5, 8, 8, 0, 0, 1'b0);    // R3 watermark equals buffer size
        run_xfer(6, 13, 6, 2, 1, 1'b0);   // R8 with back-pressure, R7 holding limit
        run_xfer(7, 9, 2, 0, 1, 1'b0);    // R4 short buffer with watermark 2, R2 gaps

        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 cmp_main + cmp_mon + cmp_br, bad_main + bad_mon + bad_br);
        $finish;
    end
endmodule